// File: doc/BRIEF.md
# Descriptor-Chained DMA Mover

This block copies data between a local memory and host memory, one 32-bit word at a time, under the control of a small register port. Software fills in descriptors, sets the enable bit for a direction and writes a command word. The engine then runs on its own. In the host-bound direction (called "write") it works through a window of up to eight descriptors. Each descriptor is a triplet that gives the local address, the host address and a byte length. The read direction (host to local) uses a single descriptor. In the write direction, bit 31 of a descriptor's length word marks the final entry of the chain.

The engine reports per-direction busy bits, per-direction error bits and a link-list error bit in a status word. When a transfer completes normally, it raises a one-cycle done pulse on a separate output for each direction, which an interrupt controller can collect. A stop or cancel command ends a transfer at the next word boundary. The cancel command also clears the error bits. Memory traffic uses two word-wide request/acknowledge ports, one for local memory and one for host memory.

The sequencer has five states:
- IDLE: waits for an accepted start command (IDLE→LOAD).
- LOAD: takes the current descriptor. It leaves for IDLE on a pending stop or on a zero length, and otherwise goes to SRC.
- SRC: requests the source word and goes to DST on acknowledge.
- DST: writes the word to the destination. On acknowledge it goes to IDLE if a stop is pending, to ADV if this was the last word, and otherwise back to SRC.
- ADV: finishes a descriptor. It goes to IDLE with a done pulse or a link error, or back to LOAD for the next write triplet.

Top module: `dma_list_engine`

## Requirements
- R1: After reset the status word reads 0, the enable word reads 0, and neither memory port requests.
- R2: The register map uses these byte offsets:
  - 0x04: status, read-only.
  - 0x08: read-list host pointer.
  - 0x0C: write-list host pointer.
  - 0x10: enable (bit0 read, bit1 write).
  - 0x80–0xDC: descriptor window of 24 words, where triplet k sits at 0x80+12k and its words are in the order local address, host address, length.
  - 0xE0, 0xE4, 0xE8: read descriptor host address, local address and length.
  
  All of these read back as written. Reading the command offset 0x00 returns 0.
- R3: Writing 1 (read start) or 2 (write start) to offset 0x00 starts a transfer only if the matching enable bit is set and both busy bits are 0. Otherwise the command has no effect.
- R4: A write-direction descriptor copies ceil(len/4) words from local memory to host memory. Both addresses step by 4 per word, and only length bits 30:0 count.
- R5: The write direction handles triplets in ascending order starting at triplet 0. It finishes after the first triplet whose length has bit 31 set.
- R6: A read start copies ceil(len/4) words from the host address at 0xE4's partner 0xE0 to the local address at 0xE4. Length bit 31 is ignored.
- R7: The status bits are: bit0 read busy, bit1 write busy, bit2 read error, bit3 write error, bit4 link-list error. A busy bit stays high for the whole active transfer. Normal completion gives exactly one single-cycle pulse on `rd_done` or `wr_done`.
- R8: A descriptor with length 0, or eight write triplets with no final flag, ends the transfer. It sets bit4 and the error bit of that direction, clears busy and gives no done pulse.
- R9: Command 4 (stop) or 0 (cancel) written during a transfer clears busy once the destination write in progress completes. No error bit is set and no done pulse is given. Command 0 also clears bits 4:2.
- R10: At most one memory port requests at a time. A request, its address and its write data stay unchanged until the port acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| loc_req | output | 1 | Local memory request |
| loc_we | output | 1 | Local memory write (1) or read (0) |
| loc_addr | output | 32 | Local memory byte address |
| loc_wdata | output | 32 | Local memory write data |
| loc_ack | input | 1 | Local memory acknowledge |
| loc_rdata | input | 32 | Local memory read data, valid with acknowledge |
| hst_req | output | 1 | Host memory request |
| hst_we | output | 1 | Host memory write (1) or read (0) |
| hst_addr | output | 32 | Host memory byte address |
| hst_wdata | output | 32 | Host memory write data |
| hst_ack | input | 1 | Host memory acknowledge |
| hst_rdata | input | 32 | Host memory read data, valid with acknowledge |
| rd_done | output | 1 | One-cycle pulse when a read transfer completes |
| wr_done | output | 1 | One-cycle pulse when a write chain completes |

## Verification
The hold checks assume that a memory port acknowledges only while its request is high and holds the acknowledge for a single cycle. The bench's memory models register the acknowledge from the request and drop it after one cycle. The start-gating check assumes that commands arrive one at a time through the register strobe. The bench issues each command with a task that pulses `reg_wr` for one cycle and keeps every descriptor address inside the 1 KB space that its memory models decode.

// File: rtl/dma_list_pkg.sv
package dma_list_pkg;

    localparam int DW = 32;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_STAT   = 8'h04;
    localparam logic [7:0] A_RDPTR  = 8'h08;
    localparam logic [7:0] A_WRPTR  = 8'h0C;
    localparam logic [7:0] A_EN     = 8'h10;
    localparam logic [7:0] WIN_BASE = 8'h80;

    localparam logic [DW-1:0] CMD_CANCEL = 32'd0;
    localparam logic [DW-1:0] CMD_READ   = 32'd1;
    localparam logic [DW-1:0] CMD_WRITE  = 32'd2;
    localparam logic [DW-1:0] CMD_STOP   = 32'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SRC,
        ST_DST,
        ST_ADV
    } dma_state_e;

    typedef struct packed {
        logic [DW-1:0] loc;
        logic [DW-1:0] hst;
        logic [DW-1:0] len;
    } desc_t;

endpackage

// File: rtl/dma_list_regs.sv
module dma_list_regs
    import dma_list_pkg::*;
#(
    parameter int NDESC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [4:0]           status_i,
    input  logic [IDXW-1:0]      wsel,
    output desc_t                wdesc,
    output desc_t                rdesc,
    output logic [1:0]           en_o,
    output logic                 cmd_stb,
    output logic [DW-1:0]        cmd_code
);
    localparam int IDXW      = (NDESC > 1) ? $clog2(NDESC) : 1;
    localparam int WIN_WORDS = 3 * NDESC;
    localparam int WOW       = $clog2(WIN_WORDS);
    localparam logic [7:0] RDD_BASE = 8'(int'(WIN_BASE) + 4 * WIN_WORDS);

    logic [DW-1:0] win_q [WIN_WORDS];
    logic [DW-1:0] rd_ptr_q, wr_ptr_q;
    logic [DW-1:0] rdd_hst_q, rdd_loc_q, rdd_len_q;
    logic [1:0]    en_q;
    logic          win_hit;
    logic [WOW-1:0] widx;
    desc_t         win_desc [NDESC];

    assign win_hit = (reg_addr >= WIN_BASE) && (reg_addr < RDD_BASE);
    assign widx    = WOW'((reg_addr - WIN_BASE) >> 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q  <= '0;
            wr_ptr_q  <= '0;
            rdd_hst_q <= '0;
            rdd_loc_q <= '0;
            rdd_len_q <= '0;
            en_q      <= '0;
            for (int k = 0; k < WIN_WORDS; k++) win_q[k] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_RDPTR)          rd_ptr_q  <= reg_wdata;
            if (reg_addr == A_WRPTR)          wr_ptr_q  <= reg_wdata;
            if (reg_addr == A_EN)             en_q      <= reg_wdata[1:0];
            if (reg_addr == RDD_BASE)         rdd_hst_q <= reg_wdata;
            if (reg_addr == RDD_BASE + 8'd4)  rdd_loc_q <= reg_wdata;
            if (reg_addr == RDD_BASE + 8'd8)  rdd_len_q <= reg_wdata;
            if (win_hit) begin
                for (int k = 0; k < WIN_WORDS; k++)
                    if (widx == WOW'(k)) win_q[k] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STAT)                reg_rdata = {27'b0, status_i};
        else if (reg_addr == A_RDPTR)          reg_rdata = rd_ptr_q;
        else if (reg_addr == A_WRPTR)          reg_rdata = wr_ptr_q;
        else if (reg_addr == A_EN)             reg_rdata = {30'b0, en_q};
        else if (reg_addr == RDD_BASE)         reg_rdata = rdd_hst_q;
        else if (reg_addr == RDD_BASE + 8'd4)  reg_rdata = rdd_loc_q;
        else if (reg_addr == RDD_BASE + 8'd8)  reg_rdata = rdd_len_q;
        else if (win_hit)                      reg_rdata = win_q[widx];
    end

    generate
        for (genvar g = 0; g < NDESC; g++) begin : g_trip
            assign win_desc[g] = '{loc: win_q[3*g], hst: win_q[3*g+1], len: win_q[3*g+2]};
        end
    endgenerate

    assign wdesc    = win_desc[wsel];
    assign rdesc    = '{loc: rdd_loc_q, hst: rdd_hst_q, len: rdd_len_q};
    assign en_o     = en_q;
    assign cmd_stb  = reg_wr && (reg_addr == A_CTRL);
    assign cmd_code = reg_wdata;

endmodule

// File: rtl/dma_list_walker.sv
module dma_list_walker
    import dma_list_pkg::*;
#(
    parameter int NDESC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_stb,
    input  logic [DW-1:0]   cmd_code,
    input  logic [1:0]      en,
    input  desc_t           wdesc,
    input  desc_t           rdesc,
    output logic [IDXW-1:0] wsel,
    output logic [4:0]      status,
    output logic            rd_done,
    output logic            wr_done,
    output logic            loc_req,
    output logic            loc_we,
    output logic [DW-1:0]   loc_addr,
    output logic [DW-1:0]   loc_wdata,
    input  logic            loc_ack,
    input  logic [DW-1:0]   loc_rdata,
    output logic            hst_req,
    output logic            hst_we,
    output logic [DW-1:0]   hst_addr,
    output logic [DW-1:0]   hst_wdata,
    input  logic            hst_ack,
    input  logic [DW-1:0]   hst_rdata
);
    localparam int IDXW = (NDESC > 1) ? $clog2(NDESC) : 1;
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NDESC - 1);

    dma_state_e     state_q, state_d;
    logic           dir_q;          // 1: local to host, 0: host to local
    logic [IDXW-1:0] idx_q;
    logic [DW-1:0]  src_q, dst_q, buf_q;
    logic [30:0]    rem_q;
    logic           last_q, stop_q;
    logic           rerr_q, werr_q, lerr_q;
    desc_t          cur;
    logic           go_rd, go_wr, halt, stop_now, src_ack, dst_ack, busy;

    assign cur      = dir_q ? wdesc : rdesc;
    assign go_rd    = cmd_stb && cmd_code == CMD_READ  && en[0] && state_q == ST_IDLE;
    assign go_wr    = cmd_stb && cmd_code == CMD_WRITE && en[1] && state_q == ST_IDLE;
    assign halt     = cmd_stb && (cmd_code == CMD_CANCEL || cmd_code == CMD_STOP);
    assign stop_now = stop_q || halt;
    assign src_ack  = dir_q ? loc_ack : hst_ack;
    assign dst_ack  = dir_q ? hst_ack : loc_ack;
    assign busy     = state_q != ST_IDLE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_rd || go_wr) state_d = ST_LOAD;
            ST_LOAD: begin
                if (stop_now || cur.len[30:0] == '0) state_d = ST_IDLE;
                else                                 state_d = ST_SRC;
            end
            ST_SRC:  if (src_ack) state_d = ST_DST;
            ST_DST: begin
                if (dst_ack) begin
                    if (stop_now)              state_d = ST_IDLE;
                    else if (rem_q <= 31'd4)   state_d = ST_ADV;
                    else                       state_d = ST_SRC;
                end
            end
            ST_ADV: begin
                if (!dir_q || last_q || idx_q == IDX_LAST) state_d = ST_IDLE;
                else                                        state_d = ST_LOAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0; idx_q <= '0; src_q <= '0; dst_q <= '0; buf_q <= '0;
            rem_q <= '0; last_q <= 1'b0; stop_q <= 1'b0;
            rerr_q <= 1'b0; werr_q <= 1'b0; lerr_q <= 1'b0;
            rd_done <= 1'b0; wr_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            wr_done <= 1'b0;
            if (halt && busy) stop_q <= 1'b1;
            if (cmd_stb && cmd_code == CMD_CANCEL) begin
                rerr_q <= 1'b0; werr_q <= 1'b0; lerr_q <= 1'b0;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (go_rd || go_wr) begin
                        dir_q  <= go_wr;
                        idx_q  <= '0;
                        stop_q <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (stop_now) begin
                        stop_q <= 1'b0;
                    end else if (cur.len[30:0] == '0) begin
                        lerr_q <= 1'b1;
                        if (dir_q) werr_q <= 1'b1;
                        else       rerr_q <= 1'b1;
                    end else begin
                        src_q  <= dir_q ? cur.loc : cur.hst;
                        dst_q  <= dir_q ? cur.hst : cur.loc;
                        rem_q  <= cur.len[30:0];
                        last_q <= cur.len[31] && dir_q;
                    end
                end
                ST_SRC: if (src_ack) buf_q <= dir_q ? loc_rdata : hst_rdata;
                ST_DST: begin
                    if (dst_ack) begin
                        src_q <= src_q + 32'd4;
                        dst_q <= dst_q + 32'd4;
                        rem_q <= rem_q - 31'd4;
                        if (stop_now) stop_q <= 1'b0;
                    end
                end
                ST_ADV: begin
                    if (!dir_q)                rd_done <= 1'b1;
                    else if (last_q)           wr_done <= 1'b1;
                    else if (idx_q == IDX_LAST) begin
                        lerr_q <= 1'b1;
                        werr_q <= 1'b1;
                    end else                   idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        loc_req   = (state_q == ST_SRC && dir_q) || (state_q == ST_DST && !dir_q);
        hst_req   = (state_q == ST_SRC && !dir_q) || (state_q == ST_DST && dir_q);
        loc_we    = state_q == ST_DST;
        hst_we    = state_q == ST_DST;
        loc_addr  = dir_q ? src_q : dst_q;
        hst_addr  = dir_q ? dst_q : src_q;
        loc_wdata = buf_q;
        hst_wdata = buf_q;
        wsel      = idx_q;
        status    = {lerr_q, werr_q, rerr_q, busy && dir_q, busy && !dir_q};
    end

endmodule

// File: rtl/dma_list_engine.sv
module dma_list_engine
    import dma_list_pkg::*;
#(
    parameter int NDESC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        loc_req,
    output logic        loc_we,
    output logic [31:0] loc_addr,
    output logic [31:0] loc_wdata,
    input  logic        loc_ack,
    input  logic [31:0] loc_rdata,
    output logic        hst_req,
    output logic        hst_we,
    output logic [31:0] hst_addr,
    output logic [31:0] hst_wdata,
    input  logic        hst_ack,
    input  logic [31:0] hst_rdata,
    output logic        rd_done,
    output logic        wr_done
);
    localparam int IDXW = (NDESC > 1) ? $clog2(NDESC) : 1;

    desc_t           wdesc, rdesc;
    logic [IDXW-1:0] wsel;
    logic            cmd_stb;
    logic [DW-1:0]   cmd_code;
    logic [1:0]      en_w;
    logic [4:0]      status_w;

    dma_list_regs #(.NDESC(NDESC)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_i(status_w),
        .wsel(wsel), .wdesc(wdesc), .rdesc(rdesc), .en_o(en_w),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code)
    );

    dma_list_walker #(.NDESC(NDESC)) u_walk (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .en(en_w), .wdesc(wdesc), .rdesc(rdesc), .wsel(wsel), .status(status_w),
        .rd_done(rd_done), .wr_done(wr_done),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata)
    );

endmodule

// File: rtl/dma_list_chk.sv
module dma_list_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [1:0]  en,
    input logic [4:0]  status,
    input logic        loc_req,
    input logic        loc_ack,
    input logic [31:0] loc_addr,
    input logic [31:0] loc_wdata,
    input logic        hst_req,
    input logic        hst_ack,
    input logic [31:0] hst_addr,
    input logic [31:0] hst_wdata,
    input logic        rd_done,
    input logic        wr_done
);
    // R10
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_req && hst_req));

    // R10
    loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req && !loc_ack |=> loc_req && $stable(loc_addr) && $stable(loc_wdata));

    // R10
    hst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_req && !hst_ack |=> hst_req && $stable(hst_addr) && $stable(hst_wdata));

    // R7
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status[1:0]) <= 1);

    // R7
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R3
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == 8'h00 && reg_wdata == 32'd2 && !en[1] && status[1:0] == 2'b00
        |=> status[1] == 1'b0);

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> status[1:0] == 2'b00 && !wr_done && !rd_done);

endmodule

bind dma_list_engine dma_list_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en(en_w), .status(status_w),
    .loc_req(loc_req), .loc_ack(loc_ack), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .hst_req(hst_req), .hst_ack(hst_ack), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .rd_done(rd_done), .wr_done(wr_done)
);

// File: tb/test_dma_list_engine.sv
module test_dma_list_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        loc_req, loc_we, hst_req, hst_we;
    logic [31:0] loc_addr, loc_wdata, hst_addr, hst_wdata;
    logic        loc_ack = 1'b0, hst_ack = 1'b0;
    logic [31:0] loc_rdata, hst_rdata;
    logic        rd_done, wr_done;

    logic [31:0] lmem [256];
    logic [31:0] hmem [256];
    int n_chk = 0, n_fail = 0, rdc = 0, wrc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_list_engine i_dma_list_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_ack(loc_ack), .loc_rdata(loc_rdata),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .rd_done(rd_done), .wr_done(wr_done)
    );

    assign loc_rdata = lmem[loc_addr[9:2]];
    assign hst_rdata = hmem[hst_addr[9:2]];

    always @(posedge clk) begin
        if (loc_req && loc_ack && loc_we) lmem[loc_addr[9:2]] <= loc_wdata;
        if (hst_req && hst_ack && hst_we) hmem[hst_addr[9:2]] <= hst_wdata;
        loc_ack <= loc_req && !loc_ack;
        hst_ack <= hst_req && !hst_ack;
        if (rd_done) rdc <= rdc + 1;
        if (wr_done) wrc <= wrc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rrd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int c = 0; c < 2000; c++) begin
            rrd(8'h04, s);
            if (s[1:0] == 2'b00) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic set_trip(input int k, input logic [31:0] l, input logic [31:0] h,
                            input logic [31:0] n);
        rwr(8'(8'h80 + 12*k), l);
        rwr(8'(8'h84 + 12*k), h);
        rwr(8'(8'h88 + 12*k), n);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rrd(8'h04, d); chk("R1 status", d, 32'h0);
        rrd(8'h10, d); chk("R1 enable", d, 32'h0);
        chk("R1 ports idle", {30'b0, loc_req, hst_req}, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        rwr(8'h08, 32'h1111_2222); rwr(8'h0C, 32'h3333_4444);
        rwr(8'hDC, 32'h5555_6666); rwr(8'hE8, 32'h7777_8888);
        rrd(8'h08, d); chk("R2 read ptr", d, 32'h1111_2222);
        rrd(8'h0C, d); chk("R2 write ptr", d, 32'h3333_4444);
        rrd(8'hDC, d); chk("R2 window top", d, 32'h5555_6666);
        rrd(8'hE8, d); chk("R2 read length", d, 32'h7777_8888);
        rrd(8'h00, d); chk("R2 command reads 0", d, 32'h0);
    endtask

    task automatic t_no_enable();
        logic [31:0] d;
        int w0 = wrc, r0 = rdc;
        set_trip(0, 32'h000, 32'h100, 32'h8000_0004);
        rwr(8'h00, 32'd2);
        rwr(8'h00, 32'd1);
        repeat (20) @(negedge clk);
        rrd(8'h04, d); chk("R3 start without enable", d, 32'h0);
        chk("R3 host untouched", hmem[8'h40], 32'h0);
        chk("R3 no done", 32'(wrc - w0 + rdc - r0), 32'h0);
    endtask

    task automatic t_write_chain();
        logic [31:0] d;
        int w0 = wrc;
        rwr(8'h10, 32'd3);
        set_trip(0, 32'h000, 32'h100, 32'h0000_0008);
        set_trip(1, 32'h020, 32'h180, 32'h8000_0006);
        rwr(8'h00, 32'd2);
        rrd(8'h04, d); chk("R7 write busy", d, 32'h2);
        wait_idle();
        chk("R4 word 0", hmem[8'h40], lmem[0]);
        chk("R4 word 1", hmem[8'h41], lmem[1]);
        chk("R5 second triplet w0", hmem[8'h60], lmem[8]);
        chk("R4 ceil length w1", hmem[8'h61], lmem[9]);
        chk("R5 stops at last flag", hmem[8'h62], 32'h0);
        rrd(8'h04, d); chk("R7 status after write", d, 32'h0);
        chk("R7 one write done", 32'(wrc - w0), 32'd1);
    endtask

    task automatic t_read();
        logic [31:0] d;
        int r0 = rdc, w0 = wrc;
        rwr(8'hE0, 32'h300); rwr(8'hE4, 32'h200); rwr(8'hE8, 32'h8000_000C);
        rwr(8'h00, 32'd1);
        rrd(8'h04, d); chk("R7 read busy", d, 32'h1);
        wait_idle();
        for (int i = 0; i < 3; i++) chk("R6 read word", lmem[8'h80 + i], hmem[8'hC0 + i]);
        chk("R6 length bit31 ignored", lmem[8'h83], 32'h0);
        chk("R7 one read done", 32'(rdc - r0), 32'd1);
        chk("R7 no write done", 32'(wrc - w0), 32'd0);
    endtask

    task automatic t_zero_len();
        logic [31:0] d;
        int w0 = wrc;
        set_trip(0, 32'h000, 32'h100, 32'h0);
        rwr(8'h00, 32'd2);
        wait_idle();
        rrd(8'h04, d); chk("R8 zero length error", d, 32'h18);
        chk("R8 no done on error", 32'(wrc - w0), 32'd0);
        rwr(8'h00, 32'd0);
        rrd(8'h04, d); chk("R9 cancel clears errors", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        int w0 = wrc;
        for (int k = 0; k < 8; k++) set_trip(k, 32'(4*k), 32'(32'h280 + 4*k), 32'd4);
        rwr(8'h00, 32'd2);
        wait_idle();
        rrd(8'h04, d); chk("R8 chain overflow", d, 32'h18);
        chk("R5 first triplet", hmem[8'hA0], lmem[0]);
        chk("R5 eighth triplet", hmem[8'hA7], lmem[7]);
        chk("R8 no done on overflow", 32'(wrc - w0), 32'd0);
        rwr(8'h00, 32'd0);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        int r0 = rdc, w0 = wrc;
        rwr(8'hE0, 32'h300); rwr(8'hE4, 32'h240); rwr(8'hE8, 32'd64);
        rwr(8'h00, 32'd1);
        rwr(8'h00, 32'd2);
        rrd(8'h04, d); chk("R3 start ignored while busy", d, 32'h1);
        repeat (10) @(negedge clk);
        rwr(8'h00, 32'd4);
        wait_idle();
        rrd(8'h04, d); chk("R9 stop status", d, 32'h0);
        chk("R9 first word moved", lmem[8'h90], hmem[8'hC0]);
        chk("R9 tail not moved", lmem[8'h9F], 32'h0);
        chk("R9 no read done", 32'(rdc - r0), 32'd0);
        chk("R3 no write ran", 32'(wrc - w0), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            lmem[i] = (i < 64) ? (32'hA000_0000 | 32'(i)) : 32'h0;
            hmem[i] = (i >= 8'hC0 && i < 8'hD0) ? (32'h5000_0000 | 32'(i)) : 32'h0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_no_enable();
        t_write_chain();
        t_read();
        t_zero_len();
        t_overflow();
        t_stop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule